// File: doc/BRIEF.md
# Nested Region Execution-Time Monitor

This block observes the program counter of a processor core on every clock cycle and times nested single-entry single-exit code regions. The regions form a tree that sits in a separate region-tree memory. The block keeps the innermost active region in working registers. It saves each enclosing region, with its elapsed cycle count, on a hardware stack. Only the innermost region accumulates cycles, so an enclosing region's count is paused while a nested region runs. The count resumes from its saved value when the nested region is left.

The block reads one window of child descriptors per cycle. It sends the region-tree memory a request holding a first-child index and a child count. The memory answers in the same cycle with the entry address, exit address, first-child index and child count of each child slot. Every region is held against a single programmed cycle bound. When a count goes beyond that bound, a sticky alarm is raised. The processor is never stalled: a new PC is taken every cycle, and the same PC may repeat across cycles.

Top module: `region_time_monitor`

## Requirements
- R1: While reset is held (synchronous, active low), the block loads the root region from the root descriptor inputs with a count of zero. It also empties the stack and clears alarm and error. After reset, with the PC strobe low, the request outputs show the root's first-child index and child count.
- R2: On a cycle with no region change, the innermost count rises by one and saturates at its all-ones value instead of wrapping. With the bound equal to the all-ones count, the alarm never rises.
- R3: With the strobe high, the block enters child slot k when the PC equals that slot's entry address and k is below the child count of the region being searched. The lowest matching slot wins. The current region is then saved on the stack, and the child becomes innermost with a count of 1 for that cycle. Slots at or beyond the child count are ignored.
- R4: With the strobe high, when the PC equals the innermost region's exit address and the stack is not empty, the block pops the enclosing region and resumes its count at the saved value plus one.
- R5: Exit is tested before entry within the same cycle. When both happen, the entry search uses the enclosing region's children. The request outputs carry that region's descriptor in that cycle, and the stack depth is unchanged.
- R6: With the strobe low, no entry or exit takes place, but counting continues.
- R7: The alarm is registered and rises at the clock edge where the updated count becomes strictly greater than the bound. A count equal to the bound does not raise it. Once raised, the alarm stays high until reset.
- R8: An exit from the root (stack empty), or an entry with the stack full, leaves region state and stack unchanged. It sets both the sticky error flag and the alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_i | input | ADDR_W | Observed program counter |
| pc_valid_i | input | 1 | PC strobe; enables entry and exit matching |
| bound_i | input | CNT_W | Global cycle bound for every region |
| root_exit_i | input | ADDR_W | Root region exit address, loaded in reset |
| root_first_i | input | IDX_W | Root first-child index, loaded in reset |
| root_nch_i | input | NCH_W | Root child count, loaded in reset |
| req_first_o | output | IDX_W | First-child index of the region searched this cycle |
| req_nch_o | output | NCH_W | Child count of the region searched this cycle |
| lk_entry_i | input | ARITY*ADDR_W | Entry address per child slot |
| lk_exit_i | input | ARITY*ADDR_W | Exit address per child slot |
| lk_first_i | input | ARITY*IDX_W | First-child index per child slot |
| lk_nch_i | input | ARITY*NCH_W | Child count per child slot |
| alarm_o | output | 1 | Sticky alarm |
| error_o | output | 1 | Sticky stack overflow or underflow flag |

## Verification
The request outputs are combinational. They follow the PC in the same cycle, and in a cycle with the strobe low they show the innermost region. Because of this, the bench reads region state by lowering the strobe one time unit after each clock edge. The alarm and error flag are registered: each is checked right after the edge that takes in the offending PC, or the edge that makes the count exceed the bound. The bench counts every edge since reset release to get the exact edge at which each alarm is due. It checks that the alarm is still low one edge earlier, so a count that was paused too little or too much shows up as an early or late alarm.

// File: rtl/rtm_pkg.sv
// Package shared by the region time monitor.
// Holds the per-cycle action code chosen by the control logic.
package rtm_pkg;
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,  // no region change
        ACT_ENTER = 2'd1,  // push current, enter child
        ACT_LEAVE = 2'd2,  // pop to enclosing region
        ACT_SWAP  = 2'd3   // leave and enter a sibling in one cycle
    } rtm_act_e;
endpackage

// File: rtl/rtm_child_match.sv
// Compares the PC against the entry addresses of up to ARITY child slots.
// Assumes the slot descriptors belong to the region named by the request.
// Slots at or beyond the child count are masked; the lowest matching slot wins.
module rtm_child_match #(
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 12,
    parameter int NCH_W  = 4,
    parameter int ARITY  = 8
) (
    input  logic [ADDR_W-1:0]       pc_i,
    input  logic                    valid_i,
    input  logic [NCH_W-1:0]        nch_i,
    input  logic [ARITY*ADDR_W-1:0] ent_i,
    input  logic [ARITY*ADDR_W-1:0] ext_i,
    input  logic [ARITY*IDX_W-1:0]  fst_i,
    input  logic [ARITY*NCH_W-1:0]  cnc_i,
    output logic                    hit_o,
    output logic [NCH_W-1:0]        slot_o,
    output logic [ADDR_W-1:0]       sel_ext_o,
    output logic [IDX_W-1:0]        sel_fst_o,
    output logic [NCH_W-1:0]        sel_nch_o
);
    logic [ARITY-1:0] slot_hit;

    for (genvar k = 0; k < ARITY; k++) begin : g_slot
        // One comparator per slot, masked by the child count
        assign slot_hit[k] = valid_i
                          && ((NCH_W+1)'(k) < {1'b0, nch_i})
                          && (pc_i == ent_i[k*ADDR_W +: ADDR_W]);
    end

    // Priority pick: the lowest matching slot supplies the descriptor
    always_comb begin
        hit_o     = |slot_hit;
        slot_o    = '0;
        sel_ext_o = '0;
        sel_fst_o = '0;
        sel_nch_o = '0;
        for (int k = ARITY - 1; k >= 0; k--) begin
            if (slot_hit[k]) begin
                slot_o    = NCH_W'(k);
                sel_ext_o = ext_i[k*ADDR_W +: ADDR_W];
                sel_fst_o = fst_i[k*IDX_W +: IDX_W];
                sel_nch_o = cnc_i[k*NCH_W +: NCH_W];
            end
        end
    end
endmodule

// File: rtl/rtm_frame_stack.sv
// Stack of saved enclosing-region frames, DEPTH entries of FRAME_W bits.
// Assumes push and pop never arrive together and are never issued when
// full or empty; the caller filters those cases.
module rtm_frame_stack #(
    parameter int FRAME_W = 64,
    parameter int DEPTH   = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_i,
    input  logic               pop_i,
    input  logic [FRAME_W-1:0] wdata_i,
    output logic [FRAME_W-1:0] rdata_o,
    output logic [$clog2(DEPTH+1)-1:0] level_o,
    output logic               full_o,
    output logic               empty_o
);
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [FRAME_W-1:0] mem [DEPTH];
    logic [LVL_W-1:0]   lvl;

    assign level_o = lvl;
    assign full_o  = (lvl == LVL_W'(DEPTH));
    assign empty_o = (lvl == '0);
    assign rdata_o = empty_o ? '0 : mem[PTR_W'(lvl - 1'b1)];

    // Occupancy counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            lvl <= '0;
        else if (push_i)
            lvl <= lvl + 1'b1;
        else if (pop_i)
            lvl <= lvl - 1'b1;
    end

    // Frame storage write on push
    always_ff @(posedge clk) begin
        if (push_i)
            mem[PTR_W'(lvl)] <= wdata_i;
    end

    AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o); // R8
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o); // R8
    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (lvl == $past(lvl) + 1'b1)); // R3
endmodule

// File: rtl/region_time_monitor.sv
// Nested region execution-time monitor.
// Tracks the innermost active code region in registers and saves enclosing
// regions on a frame stack; only the innermost count advances. Each cycle:
// exit test, then entry test against the children of the resulting region,
// then a saturating count compared with one global bound.
// Assumes the region-tree memory answers the child request combinationally.
module region_time_monitor #(
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 24,
    parameter int IDX_W  = 12,
    parameter int NCH_W  = 4,
    parameter int DEPTH  = 64,
    parameter int ARITY  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       pc_i,
    input  logic                    pc_valid_i,
    input  logic [CNT_W-1:0]        bound_i,
    input  logic [ADDR_W-1:0]       root_exit_i,
    input  logic [IDX_W-1:0]        root_first_i,
    input  logic [NCH_W-1:0]        root_nch_i,
    output logic [IDX_W-1:0]        req_first_o,
    output logic [NCH_W-1:0]        req_nch_o,
    input  logic [ARITY*ADDR_W-1:0] lk_entry_i,
    input  logic [ARITY*ADDR_W-1:0] lk_exit_i,
    input  logic [ARITY*IDX_W-1:0]  lk_first_i,
    input  logic [ARITY*NCH_W-1:0]  lk_nch_i,
    output logic                    alarm_o,
    output logic                    error_o
);
    import rtm_pkg::*;

    localparam int FRAME_W = CNT_W + ADDR_W + IDX_W + NCH_W;
    localparam int LVL_W   = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Innermost region registers
    logic [CNT_W-1:0]  act_cnt;
    logic [ADDR_W-1:0] act_ext;
    logic [IDX_W-1:0]  act_fst;
    logic [NCH_W-1:0]  act_nch;
    logic              alarm_q, err_q;

    // Stack interface
    logic               stk_push, stk_pop, stk_full, stk_empty;
    logic [FRAME_W-1:0] stk_rdata;
    logic [LVL_W-1:0]   stk_level;
    logic [CNT_W-1:0]   par_cnt;
    logic [ADDR_W-1:0]  par_ext;
    logic [IDX_W-1:0]   par_fst;
    logic [NCH_W-1:0]   par_nch;

    // Matcher outputs
    logic              enter_hit;
    logic [NCH_W-1:0]  sel_slot;
    logic [ADDR_W-1:0] ch_ext;
    logic [IDX_W-1:0]  ch_fst;
    logic [NCH_W-1:0]  ch_nch;

    logic exit_hit, leave_ok, underflow, overflow, enter_ok, over_bound;
    rtm_act_e act;
    logic [CNT_W-1:0] base_cnt, cnt_next;

    assign {par_cnt, par_ext, par_fst, par_nch} = stk_rdata;

    // Exit test comes first; it picks which region's children are searched
    always_comb begin
        exit_hit  = pc_valid_i && (pc_i == act_ext);
        leave_ok  = exit_hit && !stk_empty;
        underflow = exit_hit && stk_empty;
        req_first_o = leave_ok ? par_fst : act_fst;
        req_nch_o   = leave_ok ? par_nch : act_nch;
    end

    rtm_child_match #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .NCH_W(NCH_W), .ARITY(ARITY)
    ) u_match (
        .pc_i      (pc_i),
        .valid_i   (pc_valid_i),
        .nch_i     (req_nch_o),
        .ent_i     (lk_entry_i),
        .ext_i     (lk_exit_i),
        .fst_i     (lk_first_i),
        .cnc_i     (lk_nch_i),
        .hit_o     (enter_hit),
        .slot_o    (sel_slot),
        .sel_ext_o (ch_ext),
        .sel_fst_o (ch_fst),
        .sel_nch_o (ch_nch)
    );

    // Action decode and saturating count of the resulting innermost region
    always_comb begin
        overflow = enter_hit && !leave_ok && stk_full;
        enter_ok = enter_hit && (leave_ok || !stk_full);
        unique case ({leave_ok, enter_ok})
            2'b01:   act = ACT_ENTER;
            2'b10:   act = ACT_LEAVE;
            2'b11:   act = ACT_SWAP;
            default: act = ACT_HOLD;
        endcase
        unique case (act)
            ACT_ENTER, ACT_SWAP: base_cnt = '0;
            ACT_LEAVE:           base_cnt = par_cnt;
            default:             base_cnt = act_cnt;
        endcase
        cnt_next   = (base_cnt == CNT_MAX) ? CNT_MAX : base_cnt + 1'b1;
        over_bound = cnt_next > bound_i;
        stk_push   = (act == ACT_ENTER);
        stk_pop    = (act == ACT_LEAVE);
    end

    rtm_frame_stack #(.FRAME_W(FRAME_W), .DEPTH(DEPTH)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (stk_push),
        .pop_i   (stk_pop),
        .wdata_i ({act_cnt, act_ext, act_fst, act_nch}),
        .rdata_o (stk_rdata),
        .level_o (stk_level),
        .full_o  (stk_full),
        .empty_o (stk_empty)
    );

    // Innermost region register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_cnt <= '0;
            act_ext <= root_exit_i;
            act_fst <= root_first_i;
            act_nch <= root_nch_i;
        end else begin
            act_cnt <= cnt_next;
            unique case (act)
                ACT_ENTER, ACT_SWAP: begin
                    act_ext <= ch_ext;
                    act_fst <= ch_fst;
                    act_nch <= ch_nch;
                end
                ACT_LEAVE: begin
                    act_ext <= par_ext;
                    act_fst <= par_fst;
                    act_nch <= par_nch;
                end
                default: ;
            endcase
        end
    end

    // Sticky alarm and error flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            alarm_q <= alarm_q | over_bound | underflow | overflow;
            err_q   <= err_q | underflow | overflow;
        end
    end

    assign alarm_o = alarm_q;
    assign error_o = err_q;

    AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_q |=> alarm_q); // R7
    AST_ERR_RAISES_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> alarm_q); // R8
    AST_IDLE_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_valid_i |=> $stable(stk_level)); // R6
    AST_ENTRY_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        enter_hit |-> (sel_slot < req_nch_o)); // R3
    AST_LEAVE_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_LEAVE) |=> (act_fst == $past(par_fst) && act_cnt == $past(par_cnt) + 1'b1)); // R4
    AST_HOLD_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_HOLD && act_cnt != CNT_MAX) |=> (act_cnt == $past(act_cnt) + 1'b1)); // R2
    AST_SWAP_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_SWAP) |=> $stable(stk_level)); // R5
endmodule

// File: tb/region_time_monitor_tb_top.sv
// Bench for region_time_monitor on a small configuration: 8-bit counts,
// 4-deep stack, 4 child slots, a ten-region tree modelled combinationally.
module region_time_monitor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W  = 8;
    localparam int ADDR_W = 24;
    localparam int IDX_W  = 12;
    localparam int NCH_W  = 4;
    localparam int DEPTH  = 4;
    localparam int ARITY  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] pc = '0;
    logic pc_valid = 1'b0;
    logic [CNT_W-1:0] bound = '1;
    logic [IDX_W-1:0] req_first;
    logic [NCH_W-1:0] req_nch;
    logic [ARITY*ADDR_W-1:0] lk_entry, lk_exit;
    logic [ARITY*IDX_W-1:0]  lk_first;
    logic [ARITY*NCH_W-1:0]  lk_nch;
    logic alarm, error;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    region_time_monitor #(
        .CNT_W(CNT_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W),
        .NCH_W(NCH_W), .DEPTH(DEPTH), .ARITY(ARITY)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .pc_i(pc), .pc_valid_i(pc_valid),
        .bound_i(bound), .root_exit_i(24'hFFFFFF), .root_first_i(12'd1),
        .root_nch_i(4'd3), .req_first_o(req_first), .req_nch_o(req_nch),
        .lk_entry_i(lk_entry), .lk_exit_i(lk_exit), .lk_first_i(lk_first),
        .lk_nch_i(lk_nch), .alarm_o(alarm), .error_o(error)
    );

    // Region tree: index -> {entry, exit, first child, child count}
    function automatic logic [63:0] region(input int i);
        case (i)
            0: return {24'h000000, 24'hFFFFFF, 12'd1, 4'd3}; // root
            1: return {24'h000100, 24'h000200, 12'd4, 4'd2}; // A
            2: return {24'h000200, 24'h000300, 12'd6, 4'd1}; // B
            3: return {24'h000400, 24'h000410, 12'd0, 4'd0}; // C
            4: return {24'h000110, 24'h00011F, 12'd0, 4'd0}; // A1
            5: return {24'h000120, 24'h000130, 12'd7, 4'd1}; // A2
            6: return {24'h000210, 24'h000220, 12'd0, 4'd0}; // B1
            7: return {24'h000124, 24'h000128, 12'd8, 4'd1}; // A2a
            8: return {24'h000125, 24'h000126, 12'd9, 4'd1}; // deep
            9: return {24'h000500, 24'h000501, 12'd0, 4'd0}; // deepest
            default: return 64'd0;
        endcase
    endfunction

    // Combinational region-tree memory answering the child request
    always_comb begin
        for (int k = 0; k < ARITY; k++) begin
            logic [63:0] d;
            d = region(int'(req_first) + k);
            lk_entry[k*ADDR_W +: ADDR_W] = d[63:40];
            lk_exit [k*ADDR_W +: ADDR_W] = d[39:16];
            lk_first[k*IDX_W  +: IDX_W]  = d[15:4];
            lk_nch  [k*NCH_W  +: NCH_W]  = d[3:0];
        end
    end

    task automatic chk(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, actual, expected);
        end
    endtask

    // Check the innermost region via the request outputs (strobe is low)
    task automatic chk_region(input string req, input int fst, input int nch);
        chk(req, int'(req_first), fst);
        chk(req, int'(req_nch), nch);
    endtask

    // One clock: drive inputs, take the edge, drop the strobe
    task automatic tick(input logic [ADDR_W-1:0] p, input logic v);
        pc = p;
        pc_valid = v;
        @(posedge clk);
        #1;
        pc_valid = 1'b0;
        pc = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick('0, 1'b0);
    endtask

    task automatic do_reset(input logic [CNT_W-1:0] b);
        rst_n = 1'b0;
        bound = b;
        idle(2);
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state
        do_reset(8'd255);
        chk("R1 alarm", alarm, 0);
        chk("R1 error", error, 0);
        chk_region("R1 root", 1, 3);

        // R2/R7: bound 5, alarm at the sixth edge, not the fifth
        do_reset(8'd5);
        idle(5);
        chk("R7 equal to bound", alarm, 0);
        idle(1);
        chk("R2 count past bound", alarm, 1);
        idle(3);
        chk("R7 sticky", alarm, 1);

        // R2: saturation, bound at all-ones never alarms
        do_reset(8'd255);
        idle(300);
        chk("R2 saturate", alarm, 0);

        // R3/R4: enclosing count pauses inside C
        do_reset(8'd20);
        idle(3);                       // root = 3
        tick(24'h000400, 1'b1);        // C = 1
        chk_region("R3 enter C", 0, 0);
        idle(15);                      // C = 16
        chk("R3 child count", alarm, 0);
        tick(24'h000410, 1'b1);        // root = 4
        chk_region("R4 back to root", 1, 3);
        idle(16);                      // root = 20
        chk("R4 resumed count at bound", alarm, 0);
        idle(1);                       // root = 21
        chk("R4 resumed count past bound", alarm, 1);

        // R5: leave A and enter sibling B in one cycle
        do_reset(8'd255);
        tick(24'h000100, 1'b1);
        chk_region("R3 enter A", 4, 2);
        pc = 24'h000200;
        pc_valid = 1'b1;
        #1;
        chk("R5 request uses parent", int'(req_first), 1);
        tick(24'h000200, 1'b1);
        chk_region("R5 swap to B", 6, 1);
        tick(24'h000124, 1'b1);        // slot 1 beyond B's count
        chk_region("R3 masked slot", 6, 1);
        tick(24'h000300, 1'b1);        // stack held only root
        chk_region("R5 depth kept", 1, 3);
        chk("R5 no error", error, 0);

        // R6: strobe low blocks entry and exit
        tick(24'h000100, 1'b0);
        chk_region("R6 no entry", 1, 3);
        tick(24'h000400, 1'b1);
        tick(24'h000410, 1'b0);
        chk_region("R6 no exit", 0, 0);
        tick(24'h000410, 1'b1);
        chk_region("R6 exit when valid", 1, 3);

        // R8: underflow on root exit
        tick(24'hFFFFFF, 1'b1);
        chk("R8 underflow error", error, 1);
        chk("R8 underflow alarm", alarm, 1);
        chk_region("R8 root kept", 1, 3);

        // R8: overflow with four frames saved
        do_reset(8'd255);
        tick(24'h000100, 1'b1);
        tick(24'h000120, 1'b1);
        tick(24'h000124, 1'b1);
        tick(24'h000125, 1'b1);
        chk_region("R3 deep chain", 9, 1);
        chk("R8 no error yet", error, 0);
        tick(24'h000500, 1'b1);
        chk("R8 overflow error", error, 1);
        chk("R8 overflow alarm", alarm, 1);
        chk_region("R8 region kept", 9, 1);
        tick(24'h000126, 1'b1);
        chk_region("R8 stack intact", 8, 1);

        // R1: reset clears flags
        do_reset(8'd255);
        chk("R1 alarm cleared", alarm, 0);
        chk("R1 error cleared", error, 0);
        chk_region("R1 root again", 1, 3);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
            $finish;
        end
    end
endmodule